// File: doc/BRIEF.md
# Backlight PWM Generator with Shadowed Byte Registers

This block produces one pulse-width-modulated output for a display backlight. It counts reference clock cycles. A byte-wide synchronous register port sets an 8-bit prescale, a 16-bit scale, a 16-bit level and an enable/invert control. One period lasts prescale × scale + 1 cycles. The output is active for the first min(level, scale) × prescale cycles of each period. The result can be steered onto a general-purpose pin through a 2-bit mode field held in a pin-control byte.

The 16-bit values are written one byte at a time. Every write lands in a shadow copy. The counter works from a separate active copy, which takes the whole shadow set at one instant. That instant is the last cycle of a period, or every cycle while the output is disabled. A half-updated value therefore never reaches the output. There is no streaming data path: the register port and the outputs are plain control pins with no handshake.

Top module: `bl_pwm_top`

## Requirements
- R1: After reset every register reads 0, the output is disabled, and `pwm_out` and `pin_out` are both low.
- R2: Register addresses are as follows:
  - 0xA0 prescale.
  - 0xA1/0xA2 scale, low and high byte.
  - 0xA3/0xA4 level, low and high byte.
  - 0xA5 control: bit 1 enable, bit 0 invert, other bits read 0.
  - 0xA6 pin control: 8 bits, all stored.

  `bus_rdata` shows the shadow value of the address presented one cycle earlier. A write to any other address is ignored, and a read of any other address returns 0.
- R3: While enabled, one period lasts prescale × scale + 1 cycles. When prescale or scale is 0, the period is one cycle and the output stays inactive.
- R4: While enabled, the output is active for the first min(level, scale) × prescale cycles of each period and inactive for the rest. A level above scale acts as scale.
- R5: Shadow values reach the counter only on the last cycle of a period while enabled. While disabled they reach it on the next clock. A 16-bit value written in two bytes during a period never acts as a mixed value.
- R6: While the enable bit is 0, the counter is held at 0 and `pwm_out` equals the invert bit.
- R7: The invert bit complements `pwm_out`, both while enabled and while disabled.
- R8: `pin_out` follows `pwm_out` only while bits 7:6 of the pin-control byte hold 2'b10. Otherwise `pin_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the address of the previous cycle |
| pwm_out | output | 1 | PWM result after inversion |
| pin_out | output | 1 | General-purpose pin level when muxed to PWM |

## Verification
- A write issued in one cycle updates the shadow at that clock edge.
- Read data for an address appears one edge after the address is presented.
- A shadow change reaches the counter at the edge that ends a period. While disabled, it reaches the counter at the next edge.
- `pwm_out` and `pin_out` change at the same edge as the counter.

A behavioural model in the bench applies these same edge rules to integer copies of the state. The bench compares all three outputs at every falling edge, away from the edge where they change. Directed checks sit at known counter positions: the first sample after an enabling write is counter 0. This lets the bench place samples exactly in the middle of a period and right after a boundary, which is where a mixed 16-bit level would show.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
  localparam int unsigned BYTE_W = 8;

  localparam logic [7:0] ADR_PRE   = 8'hA0;
  localparam logic [7:0] ADR_SCALE = 8'hA1;  // low byte, high byte follows
  localparam logic [7:0] ADR_LEVEL = 8'hA3;  // low byte, high byte follows
  localparam logic [7:0] ADR_CTRL  = 8'hA5;
  localparam logic [7:0] ADR_PIN   = 8'hA6;

  localparam int unsigned CTRL_EN_BIT  = 1;
  localparam int unsigned CTRL_INV_BIT = 0;
  localparam int unsigned PIN_FIELD_LSB = 6;  // pin 3 field, 2 bits per pin

  typedef enum logic [1:0] {
    PIN_GPIO_IN  = 2'b00,
    PIN_GPIO_OUT = 2'b01,
    PIN_PWM      = 2'b10,
    PIN_RSVD     = 2'b11
  } pin_mode_e;
endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
  import bl_pwm_pkg::*;
#(
  parameter int unsigned PRE_W = 8,
  parameter int unsigned VAL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [7:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [PRE_W-1:0]  pre_sh,
  output logic [VAL_W-1:0]  scale_sh,
  output logic [VAL_W-1:0]  level_sh,
  output logic              ctrl_en,
  output logic              ctrl_inv,
  output pin_mode_e         pin_mode,
  output logic [7:0]        bus_rdata
);
  localparam int unsigned NB = VAL_W / BYTE_W;

  logic [7:0] pin_q;
  logic [7:0] rd_nxt;

  // Shadow registers: the only state the bus can touch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_sh   <= '0;
      scale_sh <= '0;
      level_sh <= '0;
      ctrl_en  <= 1'b0;
      ctrl_inv <= 1'b0;
      pin_q    <= '0;
    end else if (bus_we) begin
      if (bus_addr == ADR_PRE) pre_sh <= bus_wdata[PRE_W-1:0];
      for (int b = 0; b < NB; b++) begin
        if (bus_addr == ADR_SCALE + 8'(b)) scale_sh[BYTE_W*b +: BYTE_W] <= bus_wdata;
        if (bus_addr == ADR_LEVEL + 8'(b)) level_sh[BYTE_W*b +: BYTE_W] <= bus_wdata;
      end
      if (bus_addr == ADR_CTRL) begin
        ctrl_en  <= bus_wdata[CTRL_EN_BIT];
        ctrl_inv <= bus_wdata[CTRL_INV_BIT];
      end
      if (bus_addr == ADR_PIN) pin_q <= bus_wdata;
    end
  end

  // Readback multiplexer
  always_comb begin
    rd_nxt = '0;
    if (bus_addr == ADR_PRE) rd_nxt = 8'(pre_sh);
    for (int b = 0; b < NB; b++) begin
      if (bus_addr == ADR_SCALE + 8'(b)) rd_nxt = scale_sh[BYTE_W*b +: BYTE_W];
      if (bus_addr == ADR_LEVEL + 8'(b)) rd_nxt = level_sh[BYTE_W*b +: BYTE_W];
    end
    if (bus_addr == ADR_CTRL) begin
      rd_nxt[CTRL_EN_BIT]  = ctrl_en;
      rd_nxt[CTRL_INV_BIT] = ctrl_inv;
    end
    if (bus_addr == ADR_PIN) rd_nxt = pin_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_nxt;
  end

  assign pin_mode = pin_mode_e'(pin_q[PIN_FIELD_LSB +: 2]);
endmodule

// File: rtl/bl_pwm_core.sv
module bl_pwm_core #(
  parameter int unsigned PRE_W = 8,
  parameter int unsigned VAL_W = 16,
  localparam int unsigned CW   = PRE_W + VAL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             inv,
  input  logic [PRE_W-1:0] pre_sh,
  input  logic [VAL_W-1:0] scale_sh,
  input  logic [VAL_W-1:0] level_sh,
  output logic             pwm_o,
  output logic [CW-1:0]    cnt_o,
  output logic [CW-1:0]    last_o,
  output logic [VAL_W-1:0] scale_act_o
);
  logic [PRE_W-1:0] pre_a;
  logic [VAL_W-1:0] scale_a, level_a, lev_eff;
  logic [CW-1:0]    cnt, last, thr;
  logic             wrap, load;

  assign last    = CW'(pre_a) * CW'(scale_a);
  assign lev_eff = (level_a > scale_a) ? scale_a : level_a;
  assign thr     = CW'(lev_eff) * CW'(pre_a);
  assign wrap    = (cnt == last);
  assign load    = !en || wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_a   <= '0;
      scale_a <= '0;
      level_a <= '0;
      cnt     <= '0;
    end else begin
      if (load) begin
        pre_a   <= pre_sh;
        scale_a <= scale_sh;
        level_a <= level_sh;
      end
      if (!en || wrap) cnt <= '0;
      else             cnt <= cnt + 1'b1;
    end
  end

  assign pwm_o       = (en && (cnt < thr)) ^ inv;
  assign cnt_o       = cnt;
  assign last_o      = last;
  assign scale_act_o = scale_a;
endmodule

// File: rtl/bl_pwm_pinmux.sv
module bl_pwm_pinmux
  import bl_pwm_pkg::*;
(
  input  pin_mode_e mode,
  input  logic      pwm_i,
  output logic      pin_o
);
  assign pin_o = (mode == PIN_PWM) && pwm_i;
endmodule

// File: rtl/bl_pwm_top.sv
module bl_pwm_top
  import bl_pwm_pkg::*;
#(
  parameter int unsigned PRE_W = 8,
  parameter int unsigned VAL_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_we,
  input  logic [7:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       pwm_out,
  output logic       pin_out
);
  localparam int unsigned CW = PRE_W + VAL_W;

  logic [PRE_W-1:0] pre_sh;
  logic [VAL_W-1:0] scale_sh, level_sh, scale_act_w;
  logic             ctrl_en, ctrl_inv, pwm_w;
  pin_mode_e        pin_mode;
  logic [CW-1:0]    cnt_w, last_w;

  bl_pwm_regs #(.PRE_W(PRE_W), .VAL_W(VAL_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .pre_sh(pre_sh), .scale_sh(scale_sh),
    .level_sh(level_sh), .ctrl_en(ctrl_en), .ctrl_inv(ctrl_inv),
    .pin_mode(pin_mode), .bus_rdata(bus_rdata)
  );

  bl_pwm_core #(.PRE_W(PRE_W), .VAL_W(VAL_W)) i_core (
    .clk(clk), .rst_n(rst_n), .en(ctrl_en), .inv(ctrl_inv),
    .pre_sh(pre_sh), .scale_sh(scale_sh), .level_sh(level_sh),
    .pwm_o(pwm_w), .cnt_o(cnt_w), .last_o(last_w), .scale_act_o(scale_act_w)
  );

  bl_pwm_pinmux i_pinmux (.mode(pin_mode), .pwm_i(pwm_w), .pin_o(pin_out));

  assign pwm_out = pwm_w;
endmodule

// File: rtl/bl_pwm_chk.sv
module bl_pwm_chk
  import bl_pwm_pkg::*;
#(
  parameter int unsigned CW    = 24,
  parameter int unsigned VAL_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctrl_en,
  input logic [1:0]       pin_mode,
  input logic             pin_out,
  input logic [CW-1:0]    cnt,
  input logic [CW-1:0]    last_a,
  input logic [VAL_W-1:0] scale_a,
  input logic [7:0]       bus_addr,
  input logic [7:0]       bus_rdata
);
  // R6: counter parked at zero after a disabled cycle
  a_r6_cnt_held: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ctrl_en) |-> cnt == '0);

  // R3: counter never runs past the end of the active period
  a_r3_cnt_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= last_a);

  // R3: period end returns the counter to zero
  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctrl_en) && ctrl_en && ($past(cnt) == $past(last_a))) |-> cnt == '0);

  // R5: active set is frozen inside a running period
  a_r5_hold_mid: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctrl_en) && ($past(cnt) != $past(last_a))) |-> scale_a == $past(scale_a));

  // R8: pin stays low unless muxed to the PWM function
  a_r8_pin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_mode != 2'b10) |-> !pin_out);

  // R2: unused control bits read as zero
  a_r2_ctrl_upper: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_addr) == ADR_CTRL) |-> bus_rdata[7:2] == '0);
endmodule

bind bl_pwm_top bl_pwm_chk #(.CW(PRE_W + VAL_W), .VAL_W(VAL_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .pin_mode(pin_mode),
  .pin_out(pin_out), .cnt(cnt_w), .last_a(last_w), .scale_a(scale_act_w),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/test_bl_pwm_top.sv
`timescale 1ns/1ps
module test_bl_pwm_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       pwm_out, pin_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  bl_pwm_top i_bl_pwm_top (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out), .pin_out(pin_out)
  );

  // Behavioural reference state
  int m_pre, m_scale, m_level, m_en, m_inv, m_pin;
  int a_pre, a_scale, a_level, m_cnt, m_rdata;

  function automatic int model_read(int adr);
    case (adr)
      'hA0: return m_pre;
      'hA1: return m_scale & 'hFF;
      'hA2: return (m_scale >> 8) & 'hFF;
      'hA3: return m_level & 'hFF;
      'hA4: return (m_level >> 8) & 'hFF;
      'hA5: return (m_en << 1) | m_inv;
      'hA6: return m_pin;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 0; m_scale = 0; m_level = 0; m_en = 0; m_inv = 0; m_pin = 0;
      a_pre = 0; a_scale = 0; a_level = 0; m_cnt = 0; m_rdata = 0;
    end else begin
      int endc;
      int rd;
      endc = a_pre * a_scale;
      rd   = model_read(int'(bus_addr));
      if (m_en == 0 || m_cnt == endc) begin
        a_pre = m_pre; a_scale = m_scale; a_level = m_level;
      end
      if (m_en == 0 || m_cnt == endc) m_cnt = 0;
      else m_cnt = m_cnt + 1;
      m_rdata = rd;
      if (bus_we) begin
        case (int'(bus_addr))
          'hA0: m_pre = int'(bus_wdata);
          'hA1: m_scale = (m_scale & 'hFF00) | int'(bus_wdata);
          'hA2: m_scale = (m_scale & 'h00FF) | (int'(bus_wdata) << 8);
          'hA3: m_level = (m_level & 'hFF00) | int'(bus_wdata);
          'hA4: m_level = (m_level & 'h00FF) | (int'(bus_wdata) << 8);
          'hA5: begin m_en = int'(bus_wdata[1]); m_inv = int'(bus_wdata[0]); end
          'hA6: m_pin = int'(bus_wdata);
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int lev, thr, ep, epin;
      lev  = (a_level > a_scale) ? a_scale : a_level;
      thr  = lev * a_pre;
      ep   = ((m_en != 0) && (m_cnt < thr)) ? 1 : 0;
      ep   = ep ^ m_inv;
      epin = (((m_pin >> 6) & 3) == 2) ? ep : 0;
      chk("R4 pwm_out vs model", int'(pwm_out), ep);
      chk("R8 pin_out vs model", int'(pin_out), epin);
      chk("R2 bus_rdata vs model", int'(bus_rdata), m_rdata);
    end
  end

  task automatic wr(int adr, int dat);
    bus_we = 1'b1; bus_addr = 8'(adr); bus_wdata = 8'(dat);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(int adr);
    bus_addr = 8'(adr);
    @(negedge clk);
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(int n, output int hi, output int phi);
    hi = 0; phi = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm_out) hi++;
      if (pin_out) phi++;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(100000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int hi, phi;
    cyc(4);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pwm_out after reset", int'(pwm_out), 0);
    chk("R1 pin_out after reset", int'(pin_out), 0);
    rd('hA5); chk("R1 control reads 0", int'(bus_rdata), 0);
    rd('hA3); chk("R1 level low reads 0", int'(bus_rdata), 0);

    // Setup: pin in PWM mode, pre 3, scale 4, level 2
    wr('hA6, 'h80); wr('hA0, 3); wr('hA1, 4); wr('hA2, 0); wr('hA3, 2); wr('hA4, 0);
    // R2 readback and unmapped address
    rd('hA0); chk("R2 prescale readback", int'(bus_rdata), 3);
    rd('hA6); chk("R2 pin control readback", int'(bus_rdata), 'h80);
    wr('h10, 'h55); rd('h10); chk("R2 unmapped reads 0", int'(bus_rdata), 0);
    wr('hA5, 'hFC); rd('hA5); chk("R2 control upper bits masked", int'(bus_rdata), 0);

    // R4 normal duty: period 13, active 6
    wr('hA5, 'h02);
    measure(39, hi, phi);
    chk("R4 active cycles over 3 periods", hi, 18);
    chk("R8 pin follows pwm", phi, 18);
    chk("R3 new period starts active", int'(pwm_out), 1);

    // R4 level above scale saturates
    wr('hA3, 9);
    cyc(12);
    measure(13, hi, phi);
    chk("R4 saturated level", hi, 12);

    // R7 invert while enabled
    wr('hA5, 'h03);
    cyc(12);
    measure(13, hi, phi);
    chk("R7 inverted active cycles", hi, 1);

    // R6 disabled: output sits at invert level
    wr('hA5, 'h01);
    chk("R6 disabled inverted level", int'(pwm_out), 1);
    measure(5, hi, phi);
    chk("R6 level held while disabled", hi, 5);
    wr('hA5, 'h00);
    chk("R6 disabled normal level", int'(pwm_out), 0);

    // R8 pin mode not PWM
    wr('hA6, 'h40);
    wr('hA5, 'h02);
    measure(13, hi, phi);
    chk("R8 pin low when not muxed", phi, 0);
    chk("R4 pwm still runs", hi, 12);

    // R3 zero prescale: one-cycle period, never active
    wr('hA5, 0); wr('hA0, 0); wr('hA5, 'h02);
    measure(10, hi, phi);
    chk("R3 zero prescale stays inactive", hi, 0);
    wr('hA5, 0);

    // R5 byte-split level change mid period
    wr('hA0, 1); wr('hA1, 'hFF); wr('hA2, 'h07); wr('hA3, 'hFF); wr('hA4, 'h03);
    wr('hA5, 'h02);              // sample index 0 = counter 0
    wr('hA4, 'h04);              // index 1
    wr('hA3, 'h00);              // index 2
    cyc('h450 - 2);
    chk("R5 no mixed level mid period", int'(pwm_out), 0);
    cyc(2048 + 'h3FF - 'h450);
    chk("R5 new level after boundary", int'(pwm_out), 1);
    rd('hA4); chk("R2 level high readback", int'(bus_rdata), 4);
    rd('hA3); chk("R2 level low readback", int'(bus_rdata), 0);

    cyc(4);
    finish_run();
  end
endmodule